// File: doc/BRIEF.md
# Converter Sample-and-Conversion Sequencer

This block is the digital control for a 12-bit successive-approximation converter with sixteen result slots. A start event can come from a self-clearing software start bit or from one of three timer outputs, and the selected event can be inverted. The block opens a sampling window, asks the analog converter for a conversion, and hands each result out on a valid/ready stream tagged with the slot it belongs to. Each slot carries its own channel number and an end-of-sequence mark.

There are four sequence modes: one slot converted once, a pass over slots converted once, one slot repeated, and a pass over slots repeated. A pass starts at a programmable start slot, walks upward (wrapping from slot 15 to slot 0) and ends on the first slot whose end-of-sequence mark is set. The sampling window either follows the trigger level directly or is timed in divided-clock ticks from a 4-bit code. Slots 0 to 7 take one code and slots 8 to 15 take another. The converter itself sits outside: it sees a one-cycle start pulse and the channel number, and answers with a done pulse and a 12-bit value.

The result stream obeys the usual rules. Once `res_valid` is high, `res_slot` and `res_data` stay fixed until a cycle with `res_ready` high. The sequencer starts no new sample while a result waits, so back-pressure stalls the whole sequence and no result is ever lost.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `res_valid` and `conv_start` are low.
- R2: Mode code 0 makes exactly one conversion on `start_slot`, and `busy` falls in the cycle after that result is accepted.
- R3: Mode code 1 converts `start_slot`, then each following slot in ascending order, wrapping from slot 15 to slot 0. The pass ends with the first slot whose `slot_eos` bit is 1. Then the block goes idle.
- R4: Mode code 2 repeats `start_slot`, and mode code 3 repeats the pass of R3. Once `enable` is low, a repeat mode finishes the conversion (mode 2) or the pass (mode 3) already under way and then goes idle.
- R5: With `multi_sample` at 0, each conversion after the first in a sequence waits for a new rising edge of the trigger. With `multi_sample` at 1, the next sample begins right after the previous result is accepted.
- R6: With `pulse_mode` at 1, a sample lasts N*(`clk_div`+1) clock cycles. N comes from the code: codes 0 to 11 map to 4, 8, 16, 32, 64, 96, 128, 192, 256, 384, 512 and 768, and codes 12 to 15 map to 1024. `conv_start` rises N*(D+1) cycles after the clock edge that first samples the trigger high. `sht_lo` applies to slots 0 to 7 and `sht_hi` to slots 8 to 15.
- R7: With `pulse_mode` at 0, the sample lasts as long as the trigger level stays high. `conv_start` is issued only after the trigger falls.
- R8: `trig_sel` picks the trigger source: 0 is the software start bit, 1 is `timer_trig[0]`, 2 is `timer_trig[1]` and 3 is `timer_trig[2]`. When `trig_inv` is 1, the chosen source is complemented. Edges on the sources that are not selected have no effect.
- R9: A `sw_start` pulse sets a start bit that clears itself one cycle later. `sw_start` may arrive in the same cycle that `enable` rises. While `enable` is low, an idle block ignores every trigger.
- R10: `busy` is high from the start of a sequence until its last result is accepted, including the time spent waiting for triggers.
- R11: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_slot` and `res_data` hold steady and no `conv_start` is issued.
- R12: `conv_chan` carries the channel of the slot being converted, and `res_data` equals the `conv_data` value returned with `conv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Conversion enable |
| sw_start | input | 1 | Software start pulse |
| timer_trig | input | 3 | Timer trigger outputs |
| trig_sel | input | 2 | Trigger source select |
| trig_inv | input | 1 | Invert selected trigger |
| seq_mode | input | 2 | Sequence mode code |
| start_slot | input | 4 | First slot of a conversion or pass |
| multi_sample | input | 1 | Self-retrigger after each result |
| pulse_mode | input | 1 | 1: timed sample window, 0: window follows trigger |
| sht_lo | input | 4 | Sample time code for slots 0 to 7 |
| sht_hi | input | 4 | Sample time code for slots 8 to 15 |
| clk_div | input | 3 | Converter clock divider minus one |
| slot_chan | input | 64 | Channel per slot, slot s at bits [4s+3:4s] |
| slot_eos | input | 16 | End-of-sequence mark per slot |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 4 | Channel for the conversion |
| conv_done | input | 1 | Conversion complete pulse |
| conv_data | input | 12 | Conversion value, valid with conv_done |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Result stream ready |
| res_slot | output | 4 | Slot of the result |
| res_data | output | 12 | Result value |
| busy | output | 1 | Sequence, sample or conversion active |

## Verification
The hardest states to reach are in the repeat modes, where `enable` is dropped part-way through a pass. There the sequencer must finish the pass and then stop, neither quitting early nor starting another round. The bench gets there by counting accepted results and clearing `enable` on the falling edge right after a chosen handshake. At that moment the block is known to be sampling a definite slot, so the exact number and order of results that must follow can be predicted. Back-pressure is reached in a similar way: `res_ready` is held low during a self-retriggering sequence, and the bench checks that no further conversion request appears.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int SHT_W  = 4;
  localparam int TICK_W = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SAMPLE,
    ST_CONV,
    ST_EMIT
  } seq_state_e;

  typedef enum logic [1:0] {
    MODE_ONE     = 2'd0,
    MODE_SEQ     = 2'd1,
    MODE_REP_ONE = 2'd2,
    MODE_REP_SEQ = 2'd3
  } seq_mode_e;

  // Code to divided-clock ticks: doubling up to 64, then alternating
  // x1 / x1.5 steps of a doubling base, saturating at 1024.
  function automatic logic [TICK_W-1:0] sample_ticks(input logic [SHT_W-1:0] code);
    logic [TICK_W-1:0] base;
    if (code >= 4'd12) return TICK_W'(1024);
    if (code < 4'd4) return TICK_W'(4) << code;
    base = TICK_W'(64) << ((code - 4'd4) >> 1);
    return code[0] ? base + (base >> 1) : base;
  endfunction

endpackage

// File: rtl/adc_seq_trigger.sv
module adc_seq_trigger #(
  parameter int NTIMER = 3,
  localparam int SEL_W = $clog2(NTIMER + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_start,
  input  logic [NTIMER-1:0] timer_trig,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic              trig_inv,
  output logic              trig_lvl,
  output logic              trig_rise
);

  logic              sw_bit;
  logic              lvl_q;
  logic [NTIMER:0]   src;

  // Start bit lives one cycle, then clears itself.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_bit <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      sw_bit <= sw_start;
      lvl_q  <= trig_lvl;
    end
  end

  assign src       = {timer_trig, sw_bit};
  assign trig_lvl  = src[trig_sel] ^ trig_inv;
  assign trig_rise = trig_lvl & ~lvl_q;

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int DIV_W  = 3,
  parameter int TICK_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TICK_W-1:0] ticks,
  input  logic              active,
  input  logic [DIV_W-1:0]  clk_div,
  output logic              done
);

  logic [DIV_W-1:0]  div_cnt;
  logic [TICK_W-1:0] remain;
  logic              tick;

  assign tick = active && (div_cnt == clk_div);
  assign done = tick && (remain == TICK_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      remain  <= '0;
    end else if (load) begin
      div_cnt <= '0;
      remain  <= ticks;
    end else if (active) begin
      if (tick) begin
        div_cnt <= '0;
        remain  <= remain - TICK_W'(1);
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end

endmodule

// File: rtl/adc_seq_step.sv
module adc_seq_step
  import adc_seq_pkg::*;
#(
  parameter int NSLOT = 16,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  seq_mode_e         mode,
  input  logic [SLOT_W-1:0] slot,
  input  logic [SLOT_W-1:0] start_slot,
  input  logic [NSLOT-1:0]  slot_eos,
  input  logic              enable,
  output logic [SLOT_W-1:0] nxt_slot,
  output logic              stop
);

  logic              last;
  logic [SLOT_W-1:0] inc;

  assign last = slot_eos[slot];
  assign inc  = (slot == SLOT_W'(NSLOT - 1)) ? '0 : slot + SLOT_W'(1);

  always_comb begin
    nxt_slot = slot;
    stop     = 1'b1;
    unique case (mode)
      MODE_ONE: begin
        stop = 1'b1;
      end
      MODE_SEQ: begin
        stop     = last;
        nxt_slot = inc;
      end
      MODE_REP_ONE: begin
        stop = !enable;
      end
      MODE_REP_SEQ: begin
        stop     = last && !enable;
        nxt_slot = last ? start_slot : inc;
      end
      default: stop = 1'b1;
    endcase
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NSLOT  = 16,
  parameter int CHAN_W = 4,
  parameter int DATA_W = 12,
  parameter int DIV_W  = 3,
  parameter int NTIMER = 3,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int SEL_W  = $clog2(NTIMER + 1),
  localparam int HALF   = NSLOT / 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    sw_start,
  input  logic [NTIMER-1:0]       timer_trig,
  input  logic [SEL_W-1:0]        trig_sel,
  input  logic                    trig_inv,
  input  logic [1:0]              seq_mode,
  input  logic [SLOT_W-1:0]       start_slot,
  input  logic                    multi_sample,
  input  logic                    pulse_mode,
  input  logic [SHT_W-1:0]        sht_lo,
  input  logic [SHT_W-1:0]        sht_hi,
  input  logic [DIV_W-1:0]        clk_div,
  input  logic [NSLOT*CHAN_W-1:0] slot_chan,
  input  logic [NSLOT-1:0]        slot_eos,
  output logic                    conv_start,
  output logic [CHAN_W-1:0]       conv_chan,
  input  logic                    conv_done,
  input  logic [DATA_W-1:0]       conv_data,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic [SLOT_W-1:0]       res_slot,
  output logic [DATA_W-1:0]       res_data,
  output logic                    busy
);

  seq_state_e        state, state_n;
  logic [SLOT_W-1:0] slot, slot_n;
  logic [SLOT_W-1:0] step_slot;
  logic              step_stop;
  logic              trig_lvl, trig_rise;
  logic              tmr_load, tmr_done, tmr_active;
  logic              fire;
  logic [SHT_W-1:0]  code_n;
  logic [TICK_W-1:0] ticks_n;

  adc_seq_trigger #(.NTIMER(NTIMER)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_start  (sw_start),
    .timer_trig(timer_trig),
    .trig_sel  (trig_sel),
    .trig_inv  (trig_inv),
    .trig_lvl  (trig_lvl),
    .trig_rise (trig_rise)
  );

  adc_seq_step #(.NSLOT(NSLOT)) u_step (
    .mode      (seq_mode_e'(seq_mode)),
    .slot      (slot),
    .start_slot(start_slot),
    .slot_eos  (slot_eos),
    .enable    (enable),
    .nxt_slot  (step_slot),
    .stop      (step_stop)
  );

  // Sample-time code follows the slot about to be sampled.
  assign code_n     = (slot_n >= SLOT_W'(HALF)) ? sht_hi : sht_lo;
  assign ticks_n    = sample_ticks(code_n);
  assign tmr_active = (state == ST_SAMPLE) && pulse_mode;

  adc_seq_timer #(.DIV_W(DIV_W), .TICK_W(TICK_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .ticks  (ticks_n),
    .active (tmr_active),
    .clk_div(clk_div),
    .done   (tmr_done)
  );

  always_comb begin
    state_n  = state;
    slot_n   = slot;
    tmr_load = 1'b0;
    fire     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (enable && trig_rise) begin
          slot_n   = start_slot;
          state_n  = ST_SAMPLE;
          tmr_load = 1'b1;
        end
      end
      ST_WAIT: begin
        if (trig_rise) begin
          state_n  = ST_SAMPLE;
          tmr_load = 1'b1;
        end
      end
      ST_SAMPLE: begin
        if (pulse_mode ? tmr_done : !trig_lvl) begin
          state_n = ST_CONV;
          fire    = 1'b1;
        end
      end
      ST_CONV: begin
        if (conv_done) state_n = ST_EMIT;
      end
      ST_EMIT: begin
        if (res_ready) begin
          if (step_stop) begin
            state_n = ST_IDLE;
          end else begin
            slot_n   = step_slot;
            state_n  = multi_sample ? ST_SAMPLE : ST_WAIT;
            tmr_load = multi_sample;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      slot       <= '0;
      conv_start <= 1'b0;
      res_valid  <= 1'b0;
      res_slot   <= '0;
      res_data   <= '0;
    end else begin
      state      <= state_n;
      slot       <= slot_n;
      conv_start <= fire;
      if (state == ST_CONV && conv_done) begin
        res_valid <= 1'b1;
        res_slot  <= slot;
        res_data  <= conv_data;
      end else if (state == ST_EMIT && res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  assign conv_chan = slot_chan[slot*CHAN_W +: CHAN_W];
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int DATA_W = 12,
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              busy,
  input logic [1:0]        seq_mode,
  input logic              res_valid,
  input logic              res_ready,
  input logic [SLOT_W-1:0] res_slot,
  input logic [DATA_W-1:0] res_data,
  input logic              conv_start,
  input logic [DATA_W-1:0] conv_data
);

  // R11
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_slot)));

  // R11
  no_start_while_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !conv_start);

  // R10
  busy_covers_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || conv_start) |-> busy);

  // R12
  result_matches_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> (res_data == $past(conv_data)));

  // R12
  start_is_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R9
  idle_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !busy) |=> !busy);

  // R2
  single_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode == 2'd0 && res_valid && res_ready) |=> !busy);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .busy      (busy),
  .seq_mode  (seq_mode),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_slot  (res_slot),
  .res_data  (res_data),
  .conv_start(conv_start),
  .conv_data (conv_data)
);

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;

  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable, sw_start, trig_inv, multi_sample, pulse_mode;
  logic [2:0]  timer_trig, clk_div;
  logic [1:0]  trig_sel, seq_mode;
  logic [3:0]  start_slot, sht_lo, sht_hi;
  logic [63:0] slot_chan;
  logic [15:0] slot_eos;
  logic        conv_start, conv_done, res_valid, res_ready, busy;
  logic [3:0]  conv_chan, res_slot;
  logic [11:0] conv_data, res_data;

  int n_chk = 0, n_fail = 0, n_pop = 0, n_conv = 0, exp_k = 0, mdl_k = 0;
  string cur_req = "R1";
  logic [15:0] exp_q[$];

  always #4 clk = ~clk;

  adc_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sw_start(sw_start),
    .timer_trig(timer_trig), .trig_sel(trig_sel), .trig_inv(trig_inv),
    .seq_mode(seq_mode), .start_slot(start_slot), .multi_sample(multi_sample),
    .pulse_mode(pulse_mode), .sht_lo(sht_lo), .sht_hi(sht_hi), .clk_div(clk_div),
    .slot_chan(slot_chan), .slot_eos(slot_eos), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_slot(res_slot),
    .res_data(res_data), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver side of the scoreboard: channel of slot s is 15-s (R12).
  task automatic expect_slot(input int s);
    exp_q.push_back({4'(s), 4'(15 - s), 8'(exp_k)});
    exp_k++;
  endtask

  // Converter model: fixed latency, data = {channel, ordinal}.
  initial begin
    conv_done = 1'b0;
    conv_data = '0;
    forever begin
      @(negedge clk);
      if (conv_start) begin
        logic [3:0] ch;
        ch = conv_chan;
        n_conv++;
        repeat (LAT) @(negedge clk);
        conv_data = {ch, 8'(mdl_k)};
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        mdl_k++;
      end
    end
  end

  // Monitor side of the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (res_valid && res_ready) begin
        n_pop++;
        if (exp_q.size() == 0) begin
          chk(1'b0, {cur_req, " unexpected result"}, int'(res_slot), -1);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk({res_slot, res_data} == e, {cur_req, " R12 result"},
              int'({res_slot, res_data}), int'(e));
        end
      end
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy) return;
    end
    chk(1'b0, {cur_req, " idle timeout"}, 1, 0);
  endtask

  task automatic wait_pops(input int target);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      #3;
      if (n_pop >= target) return;
    end
    chk(1'b0, {cur_req, " result timeout"}, n_pop, target);
  endtask

  task automatic pulse_timer(input int idx);
    @(negedge clk);
    timer_trig[idx] = 1'b1;
    repeat (2) @(negedge clk);
    timer_trig[idx] = 1'b0;
  endtask

  // Cycles from the edge that first samples timer 0 high to conv_start.
  task automatic measure(output int cyc);
    @(negedge clk);
    timer_trig[0] = 1'b1;
    cyc = 0;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      #1;
      cyc++;
      if (conv_start) break;
    end
    @(negedge clk);
    timer_trig[0] = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired during %s", cur_req);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int base, cv, cyc;
    logic [11:0] held;
    rst_n = 1'b0; enable = 1'b0; sw_start = 1'b0; timer_trig = '0;
    trig_sel = 2'd1; trig_inv = 1'b0; seq_mode = 2'd0; start_slot = '0;
    multi_sample = 1'b0; pulse_mode = 1'b1; sht_lo = '0; sht_hi = '0;
    clk_div = '0; slot_eos = '0; res_ready = 1'b1;
    for (int s = 0; s < 16; s++) slot_chan[s*4 +: 4] = 4'(15 - s);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R1";
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
    chk(conv_start == 1'b0, "R1 conv_start", conv_start, 0);

    // R9: triggers ignored while disabled
    cur_req = "R9";
    pulse_timer(0);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0 && n_conv == 0, "R9 disabled start", n_conv, 0);

    // R2 + R9: software start in the same cycle enable rises
    cur_req = "R2";
    start_slot = 4'd5;
    expect_slot(5);
    trig_sel = 2'd0;
    enable = 1'b1;
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R10 busy during sample", busy, 1);
    base = n_pop;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(n_pop == 1 && exp_q.size() == 0, "R2 one result", n_pop, 1);
    cur_req = "R9";
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R9 start bit self-cleared", busy, 0);

    // R6: sample time via code table and divider
    cur_req = "R6";
    trig_sel = 2'd1;
    start_slot = 4'd3; sht_lo = 4'd5; sht_hi = 4'd0; clk_div = 3'd2;
    expect_slot(3);
    measure(cyc);
    chk(cyc == 96 * 3 + 1, "R6 low code with divider", cyc, 96 * 3 + 1);
    wait_idle();
    start_slot = 4'd9; sht_lo = 4'd0; sht_hi = 4'd13; clk_div = 3'd0;
    expect_slot(9);
    measure(cyc);
    chk(cyc == 1025, "R6 high code saturates", cyc, 1025);
    wait_idle();
    sht_hi = 4'd0;

    // R3: sequence with wrap and end mark, self-retriggered
    cur_req = "R3";
    seq_mode = 2'd1; start_slot = 4'd14; slot_eos = 16'h0002; multi_sample = 1'b1;
    base = n_pop;
    expect_slot(14); expect_slot(15); expect_slot(0); expect_slot(1);
    pulse_timer(0);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(n_pop - base == 4 && exp_q.size() == 0, "R3 pass length", n_pop - base, 4);

    // R5: without multi-sample each conversion waits for an edge
    cur_req = "R5";
    start_slot = 4'd4; slot_eos = 16'h0020; multi_sample = 1'b0;
    base = n_pop; cv = n_conv;
    expect_slot(4); expect_slot(5);
    pulse_timer(0);
    wait_pops(base + 1);
    repeat (100) @(negedge clk);
    chk(busy == 1'b1, "R10 busy while waiting edge", busy, 1);
    chk(n_conv - cv == 1, "R5 no self retrigger", n_conv - cv, 1);
    pulse_timer(0);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(n_pop - base == 2, "R5 second edge resumes", n_pop - base, 2);

    // R11: back-pressure stalls the sequence
    cur_req = "R11";
    multi_sample = 1'b1;
    base = n_pop; cv = n_conv;
    expect_slot(4); expect_slot(5);
    res_ready = 1'b0;
    pulse_timer(0);
    for (int i = 0; i < 5000 && !res_valid; i++) @(negedge clk);
    held = res_data;
    repeat (40) @(negedge clk);
    chk(res_valid == 1'b1 && res_data == held, "R11 result held", int'(res_data), int'(held));
    chk(n_conv - cv == 1, "R11 no conversion while held", n_conv - cv, 1);
    res_ready = 1'b1;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(n_pop - base == 2, "R11 nothing lost", n_pop - base, 2);

    // R4: repeat sequence, enable dropped mid second pass
    cur_req = "R4";
    seq_mode = 2'd3; start_slot = 4'd2; slot_eos = 16'h0008;
    base = n_pop;
    expect_slot(2); expect_slot(3); expect_slot(2); expect_slot(3);
    pulse_timer(0);
    wait_pops(base + 3);
    @(negedge clk);
    enable = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(n_pop - base == 4 && exp_q.size() == 0, "R4 repeat pass finishes", n_pop - base, 4);

    // R4: repeat single slot
    enable = 1'b1;
    seq_mode = 2'd2; start_slot = 4'd7;
    base = n_pop;
    expect_slot(7); expect_slot(7); expect_slot(7);
    pulse_timer(0);
    wait_pops(base + 2);
    @(negedge clk);
    enable = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(n_pop - base == 3 && exp_q.size() == 0, "R4 repeat single stops", n_pop - base, 3);
    enable = 1'b1;

    // R8: source select and invert
    cur_req = "R8";
    seq_mode = 2'd0; multi_sample = 1'b0; start_slot = 4'd6;
    @(negedge clk);
    timer_trig = 3'b010; trig_sel = 2'd2; trig_inv = 1'b1;
    cv = n_conv;
    pulse_timer(0);
    pulse_timer(2);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0 && n_conv == cv, "R8 unselected sources ignored", n_conv - cv, 0);
    base = n_pop;
    expect_slot(6);
    timer_trig[1] = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(n_pop - base == 1, "R8 inverted falling edge starts", n_pop - base, 1);
    timer_trig = '0; trig_inv = 1'b0;
    @(negedge clk);
    trig_sel = 2'd1;

    // R7: window follows trigger level
    cur_req = "R7";
    pulse_mode = 1'b0; start_slot = 4'd0;
    cv = n_conv;
    expect_slot(0);
    @(negedge clk);
    timer_trig[0] = 1'b1;
    repeat (50) @(negedge clk);
    chk(n_conv == cv && busy == 1'b1, "R7 no conversion while high", n_conv - cv, 0);
    timer_trig[0] = 1'b0;
    repeat (3) @(negedge clk);
    #3;
    chk(n_conv - cv == 1, "R7 conversion after fall", n_conv - cv, 1);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7 result delivered", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule